// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a full-duplex synchronous serial port that hangs off a processor bus and links the processor to a codec or to another processor. Each direction has two stages. Incoming bits shift into a receive shift register, and each finished word moves as a whole into a receive holding register for the processor to read. Outgoing words written by the processor wait in a transmit holding register, then move into a transmit shift register that drives the serial data pin. The holding register in each direction lets words stream back to back with no idle bit between them.

A single data address serves both directions. A bus write to it fills the transmit holding register, and a bus read from it returns the receive holding register. A second address holds the control register. The port has four clock and frame pins: receive clock, receive frame, transmit clock and transmit frame. Each pin is bidirectional and is modelled as an input, an output and an output enable. A control bit sets whether the port drives each pin from its own generator or takes it from outside. The internal bit clock runs at one of four rates derived from the system clock. A control bit selects MSB-first or LSB-first word order. Two flags, transmit-ready and receive-ready, support polled or interrupt-driven transfers.

Top module: `sio_port`

## Requirements
- R1: After reset, obe_o is 1, ibf_o is 0, sdo_o is 0, all four pin enables are 0, and the control register reads 0 (MSB first, rate code 0).
- R2: A bus write with bus_sel=0 loads the transmit holding register and clears obe_o on the next cycle. obe_o returns to 1 when the word moves into the transmit shift register.
- R3: A bus read with bus_sel=0 returns the last received word on bus_rdata and clears ibf_o. ibf_o is set on the cycle after the rising bit-clock edge that captures the last of the 16 bits.
- R4: sdo_o changes only on falling bit-clock edges, and the serial input is sampled on rising edges. A transmit frame strobe is high for exactly one bit period. The first data bit appears on sdo_o at the falling edge where the strobe drops.
- R5: A word written while the previous word is still shifting goes out with no gap. The two words complete exactly 16 bit periods apart.
- R6: Control bits [1:0] select the internal bit-clock period: 2, 4, 8 or 16 system clocks for codes 0, 1, 2 and 3.
- R7: Control bit 2 selects the word order. 0 sends and receives the MSB first. 1 sends and receives the LSB first. A looped-back word arrives unchanged in either order.
- R8: Control bits 3, 4, 5 and 6 set the drive enable of the receive clock, receive frame, transmit clock and transmit frame pins. When a bit is 0, the matching input pin is used.
- R9: If a word completes while ibf_o is still set, the holding register takes the new word and a sticky overrun bit (control read bit 7) is set. A bus read of the control address clears that bit.
- R10: A control read (bus_sel=1) returns control bits [6:0] as written, the overrun bit at bit 7, and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the data address, 1 selects the control address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (side effects only; data is combinational) |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data |
| obe_o | output | 1 | Transmit holding register empty |
| ibf_o | output | 1 | Receive holding register full |
| rx_clk_i | input | 1 | Receive clock pin, input side |
| rx_clk_o | output | 1 | Receive clock pin, output side |
| rx_clk_oe | output | 1 | Receive clock pin drive enable |
| rx_ld_i | input | 1 | Receive frame pin, input side |
| rx_ld_o | output | 1 | Receive frame pin, output side |
| rx_ld_oe | output | 1 | Receive frame pin drive enable |
| tx_clk_i | input | 1 | Transmit clock pin, input side |
| tx_clk_o | output | 1 | Transmit clock pin, output side |
| tx_clk_oe | output | 1 | Transmit clock pin drive enable |
| tx_ld_i | input | 1 | Transmit frame pin, input side |
| tx_ld_o | output | 1 | Transmit frame pin, output side |
| tx_ld_oe | output | 1 | Transmit frame pin drive enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
A stuck transmit counter or mistimed frame strobe shows on sdo_o and tx_ld_o within one bit period, so the bench samples the strobe length and the first data bit directly. A receive frame marker that is off by one bit gives a shifted word at bus_rdata. It also moves ibf_o by one bit period, which shows in the exact 16-bit-period spacing of back-to-back completions. A wrong overrun or flag update shows on the next control or data read.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
  localparam int RATE_W = 2;

  // Control register layout, LSB at the bottom of the struct.
  typedef struct packed {
    logic              tx_ld_drv;   // bit 6
    logic              tx_clk_drv;  // bit 5
    logic              rx_ld_drv;   // bit 4
    logic              rx_clk_drv;  // bit 3
    logic              lsb_first;   // bit 2
    logic [RATE_W-1:0] rate;        // bits 1:0
  } sio_ctrl_t;

  localparam int CTRL_W = $bits(sio_ctrl_t);
endpackage

// File: rtl/sio_clkgen.sv
`timescale 1ns/1ps
module sio_clkgen #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              bit_clk
);
  localparam int DIV_W = 1 << RATE_W;

  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // Tap k toggles every 2^k cycles: period 2^(k+1) system clocks (R6)
  assign bit_clk = div_q[rate];
endmodule

// File: rtl/sio_edge.sv
`timescale 1ns/1ps
module sio_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              ld_in,
  input  logic              lsb_first,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              obe,
  output logic              ld_gen,
  output logic              sdo
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] hold_q, hold_d, sh_q, sh_d, rev, ordered;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic obe_q, obe_d, arm_q, arm_d, sdo_q, sdo_d, ldg_q, ldg_d, take;

  for (genvar i = 0; i < WORD_W; i++) begin : g_rev
    assign rev[i] = hold_q[WORD_W-1-i];
  end
  assign ordered = lsb_first ? rev : hold_q;

  always_comb begin
    hold_d = hold_q;
    sh_d   = sh_q;
    rem_d  = rem_q;
    obe_d  = obe_q;
    arm_d  = arm_q;
    sdo_d  = sdo_q;
    ldg_d  = ldg_q;
    take   = 1'b0;
    if (bit_rise) arm_d = ld_in;
    if (bit_fall) begin
      if (arm_q) begin
        arm_d = 1'b0;
        if (!obe_q) begin
          take  = 1'b1;
          sh_d  = ordered;
          sdo_d = ordered[WORD_W-1];
          rem_d = CNT_W'(WORD_W-1);
        end else begin
          sdo_d = 1'b0;
          rem_d = '0;
        end
      end else if (rem_q != '0) begin
        sh_d  = sh_q << 1;
        sdo_d = sh_q[WORD_W-2];
        rem_d = rem_q - 1'b1;
      end
    end
    if (wr_en) begin
      hold_d = wr_data;
      obe_d  = 1'b0;
    end else if (take) begin
      obe_d  = 1'b1;
    end
    // Frame strobe for the next word during the last bit (or while idle)
    if (bit_fall) ldg_d = !obe_d && (rem_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      rem_q  <= '0;
      obe_q  <= 1'b1;
      arm_q  <= 1'b0;
      sdo_q  <= 1'b0;
      ldg_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      rem_q  <= rem_d;
      obe_q  <= obe_d;
      arm_q  <= arm_d;
      sdo_q  <= sdo_d;
      ldg_q  <= ldg_d;
    end
  end

  assign obe    = obe_q;
  assign ld_gen = ldg_q;
  assign sdo    = sdo_q;
endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              ld_in,
  input  logic              sdi,
  input  logic              lsb_first,
  input  logic              rd_data,
  input  logic              rd_ctrl,
  output logic [WORD_W-1:0] word,
  output logic              ibf,
  output logic              ovr,
  output logic              done,
  output logic              ld_gen
);
  // flag_q is the frame marker chain that runs beside the data shifter
  logic [WORD_W-1:0] flag_q, flag_d, sh_q, sh_d, hold_q, hold_d, asm, rev;
  logic ibf_q, ibf_d, ovr_q, ovr_d, ldg_q, ldg_d;

  assign asm = {sh_q[WORD_W-2:0], sdi};
  for (genvar i = 0; i < WORD_W; i++) begin : g_rev
    assign rev[i] = asm[WORD_W-1-i];
  end

  assign done = bit_rise & flag_q[WORD_W-1];

  always_comb begin
    flag_d = flag_q;
    sh_d   = sh_q;
    hold_d = hold_q;
    ibf_d  = ibf_q;
    ovr_d  = ovr_q;
    ldg_d  = ldg_q;
    if (bit_rise) begin
      if (flag_q != '0) sh_d = asm;
      flag_d = ld_in ? WORD_W'(1) : (flag_q << 1);
    end
    if (bit_fall) ldg_d = (flag_q == '0) | flag_q[WORD_W-1];
    if (rd_data) ibf_d = 1'b0;
    if (rd_ctrl) ovr_d = 1'b0;
    if (done) begin
      hold_d = lsb_first ? rev : asm;
      ibf_d  = 1'b1;
      if (ibf_q && !rd_data) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      sh_q   <= '0;
      hold_q <= '0;
      ibf_q  <= 1'b0;
      ovr_q  <= 1'b0;
      ldg_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      sh_q   <= sh_d;
      hold_q <= hold_d;
      ibf_q  <= ibf_d;
      ovr_q  <= ovr_d;
      ldg_q  <= ldg_d;
    end
  end

  assign word   = hold_q;
  assign ibf    = ibf_q;
  assign ovr    = ovr_q;
  assign ld_gen = ldg_q;
endmodule

// File: rtl/sio_port.sv
`timescale 1ns/1ps
module sio_port
  import sio_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              obe_o,
  output logic              ibf_o,
  input  logic              rx_clk_i,
  output logic              rx_clk_o,
  output logic              rx_clk_oe,
  input  logic              rx_ld_i,
  output logic              rx_ld_o,
  output logic              rx_ld_oe,
  input  logic              tx_clk_i,
  output logic              tx_clk_o,
  output logic              tx_clk_oe,
  input  logic              tx_ld_i,
  output logic              tx_ld_o,
  output logic              tx_ld_oe,
  input  logic              sdi_i,
  output logic              sdo_o
);
  localparam int PAD_W = WORD_W - CTRL_W - 1;

  logic [1:0] rs_q;
  logic       rst_s_n;
  sio_ctrl_t  ctrl_q, ctrl_d;
  logic       gen_clk, rx_src, tx_src, rx_rise, rx_fall, tx_rise, tx_fall;
  logic       rx_ldg, tx_ldg, rx_done, ovr, ctrl_we, data_we, rd_data, rd_ctrl;
  logic [WORD_W-1:0] rx_word;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  assign ctrl_we = bus_wr &  bus_sel;
  assign data_we = bus_wr & ~bus_sel;
  assign rd_ctrl = bus_rd &  bus_sel;
  assign rd_data = bus_rd & ~bus_sel;

  always_comb ctrl_d = ctrl_we ? sio_ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  sio_clkgen #(.RATE_W(RATE_W)) u_gen (
    .clk(clk), .rst_n(rst_s_n), .rate(ctrl_q.rate), .bit_clk(gen_clk)
  );

  assign rx_src = ctrl_q.rx_clk_drv ? gen_clk : rx_clk_i;
  assign tx_src = ctrl_q.tx_clk_drv ? gen_clk : tx_clk_i;

  sio_edge u_rx_edge (
    .clk(clk), .rst_n(rst_s_n), .lvl(rx_src), .rise(rx_rise), .fall(rx_fall)
  );
  sio_edge u_tx_edge (
    .clk(clk), .rst_n(rst_s_n), .lvl(tx_src), .rise(tx_rise), .fall(tx_fall)
  );

  sio_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n), .bit_rise(tx_rise), .bit_fall(tx_fall),
    .ld_in(ctrl_q.tx_ld_drv ? tx_ldg : tx_ld_i), .lsb_first(ctrl_q.lsb_first),
    .wr_en(data_we), .wr_data(bus_wdata), .obe(obe_o), .ld_gen(tx_ldg),
    .sdo(sdo_o)
  );

  sio_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .bit_rise(rx_rise), .bit_fall(rx_fall),
    .ld_in(ctrl_q.rx_ld_drv ? rx_ldg : rx_ld_i), .sdi(sdi_i),
    .lsb_first(ctrl_q.lsb_first), .rd_data(rd_data), .rd_ctrl(rd_ctrl),
    .word(rx_word), .ibf(ibf_o), .ovr(ovr), .done(rx_done), .ld_gen(rx_ldg)
  );

  assign bus_rdata = bus_sel ? {{PAD_W{1'b0}}, ovr, ctrl_q} : rx_word;

  assign rx_clk_o  = gen_clk;
  assign tx_clk_o  = gen_clk;
  assign rx_ld_o   = rx_ldg;
  assign tx_ld_o   = tx_ldg;
  assign rx_clk_oe = ctrl_q.rx_clk_drv;
  assign rx_ld_oe  = ctrl_q.rx_ld_drv;
  assign tx_clk_oe = ctrl_q.tx_clk_drv;
  assign tx_ld_oe  = ctrl_q.tx_ld_drv;
endmodule

// File: rtl/sio_port_chk.sv
`timescale 1ns/1ps
module sio_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_sel,
  input logic bus_wr,
  input logic bus_rd,
  input logic obe,
  input logic ibf,
  input logic sdo,
  input logic tx_fall,
  input logic rx_done,
  input logic ovr
);
  p_obe_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel) |=> !obe);

  p_ibf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_sel && !rx_done) |=> !ibf);

  p_ibf_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> $past(rx_done));

  p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fall |=> $stable(sdo));

  p_ovr_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(ibf));
endmodule

bind sio_port sio_port_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .obe(obe_o), .ibf(ibf_o), .sdo(sdo_o),
  .tx_fall(tx_fall), .rx_done(rx_done), .ovr(ovr)
);

// File: tb/sio_port_bench.sv
`timescale 1ns/1ps
module sio_port_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic obe_o, ibf_o, sdo_o;
  logic rx_clk_o, rx_clk_oe, rx_ld_o, rx_ld_oe;
  logic tx_clk_o, tx_clk_oe, tx_ld_o, tx_ld_oe;
  logic tx_clk_i, tx_ld_i;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Loopback: transmitter drives clock and frame into the receiver pins
  sio_port u_sio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .obe_o(obe_o), .ibf_o(ibf_o),
    .rx_clk_i(tx_clk_o), .rx_clk_o(rx_clk_o), .rx_clk_oe(rx_clk_oe),
    .rx_ld_i(tx_ld_o), .rx_ld_o(rx_ld_o), .rx_ld_oe(rx_ld_oe),
    .tx_clk_i(tx_clk_i), .tx_clk_o(tx_clk_o), .tx_clk_oe(tx_clk_oe),
    .tx_ld_i(tx_ld_i), .tx_ld_o(tx_ld_o), .tx_ld_oe(tx_ld_oe),
    .sdi_i(sdo_o), .sdo_o(sdo_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input bit sel, input logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input bit sel, output logic [15:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_ibf();
    for (int i = 0; i < 400; i++) begin
      if (ibf_o) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_obe();
    for (int i = 0; i < 400; i++) begin
      if (obe_o) break;
      @(negedge clk);
    end
  endtask

  // Returns strobe length in cycles and sdo at the moment the strobe drops
  task automatic cap_first(output int len, output bit b0, output bit b1);
    len = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tx_ld_o) break;
    end
    while (tx_ld_o && len < 100) begin
      len++;
      @(negedge clk);
    end
    b0 = sdo_o;
    @(negedge clk); @(negedge clk);
    b1 = sdo_o;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(obe_o === 1'b1, "R1 obe", obe_o, 1);
    chk(ibf_o === 1'b0, "R1 ibf", ibf_o, 0);
    chk(sdo_o === 1'b0, "R1 sdo", sdo_o, 0);
    chk({tx_ld_oe, tx_clk_oe, rx_ld_oe, rx_clk_oe} === 4'h0, "R1 oe",
        {tx_ld_oe, tx_clk_oe, rx_ld_oe, rx_clk_oe}, 0);
    bread(1'b1, d);
    chk(d === 16'h0000, "R1 R10 ctrl", d, 0);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    bwrite(1'b1, 16'h0078);
    chk({tx_ld_oe, tx_clk_oe, rx_ld_oe, rx_clk_oe} === 4'hF, "R8 all drive",
        {tx_ld_oe, tx_clk_oe, rx_ld_oe, rx_clk_oe}, 4'hF);
    bread(1'b1, d);
    chk(d[6:0] === 7'h78, "R10 readback", d[6:0], 7'h78);
    bwrite(1'b1, 16'h0028);
    chk({tx_ld_oe, tx_clk_oe, rx_ld_oe, rx_clk_oe} === 4'h5, "R8 clocks only",
        {tx_ld_oe, tx_clk_oe, rx_ld_oe, rx_clk_oe}, 4'h5);
    // Go to loopback and flush anything the receiver framed on its own
    bwrite(1'b1, 16'h0060);
    repeat (60) @(negedge clk);
    bread(1'b0, d);
    bread(1'b1, d);
    chk(d === 16'h0060, "R10 loopback ctrl", d, 16'h0060);
  endtask

  task automatic t_loop();
    logic [15:0] d;
    bwrite(1'b0, 16'hA5C3);
    chk(obe_o === 1'b0, "R2 obe clear", obe_o, 0);
    wait_obe();
    chk(obe_o === 1'b1, "R2 obe set on transfer", obe_o, 1);
    wait_ibf();
    chk(ibf_o === 1'b1, "R3 ibf set", ibf_o, 1);
    bread(1'b0, d);
    chk(d === 16'hA5C3, "R3 data", d, 16'hA5C3);
    chk(ibf_o === 1'b0, "R3 ibf clear", ibf_o, 0);
  endtask

  task automatic t_timing();
    logic [15:0] d; int len; bit b0, b1;
    bwrite(1'b0, 16'h8000);
    cap_first(len, b0, b1);
    chk(len == 2, "R4 strobe one bit", len, 2);
    chk(b0 === 1'b1, "R4 R7 first bit msb", b0, 1);
    chk(b1 === 1'b0, "R4 second bit", b1, 0);
    wait_ibf();
    bread(1'b0, d);
    chk(d === 16'h8000, "R4 word", d, 16'h8000);
  endtask

  task automatic t_order();
    logic [15:0] d; int len; bit b0, b1;
    bwrite(1'b1, 16'h0064);
    bwrite(1'b0, 16'h0002);
    cap_first(len, b0, b1);
    chk(b0 === 1'b0 && b1 === 1'b1, "R7 lsb first order", {b0, b1}, 2'b01);
    wait_ibf();
    bread(1'b0, d);
    chk(d === 16'h0002, "R7 lsb loopback", d, 16'h0002);
    bwrite(1'b1, 16'h0060);
  endtask

  task automatic t_b2b();
    logic [15:0] d; int c1, c2;
    bwrite(1'b0, 16'h1234);
    wait_obe();
    bwrite(1'b0, 16'hFEDC);
    wait_ibf();
    c1 = cyc;
    bread(1'b0, d);
    chk(d === 16'h1234, "R5 first word", d, 16'h1234);
    wait_ibf();
    c2 = cyc;
    bread(1'b0, d);
    chk(d === 16'hFEDC, "R5 second word", d, 16'hFEDC);
    chk(c2 - c1 == 32, "R5 no gap", c2 - c1, 32);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    bwrite(1'b0, 16'h0F0F);
    wait_obe();
    bwrite(1'b0, 16'h3C3C);
    wait_ibf();
    repeat (45) @(negedge clk);
    bread(1'b1, d);
    chk(d === 16'h00E0, "R9 overrun set", d, 16'h00E0);
    bread(1'b0, d);
    chk(d === 16'h3C3C, "R9 overwrite", d, 16'h3C3C);
    bread(1'b1, d);
    chk(d === 16'h0060, "R9 overrun cleared", d, 16'h0060);
  endtask

  task automatic t_rate(input int s);
    int c1;
    bwrite(1'b1, 16'h0060 | 16'(s));
    repeat (4) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_clk_o) break;
    end
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!tx_clk_o) break;
    end
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_clk_o) break;
    end
    c1 = cyc;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!tx_clk_o) break;
    end
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_clk_o) break;
    end
    chk(cyc - c1 == (2 << s), "R6 period", cyc - c1, 2 << s);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    report();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; tx_clk_i = 1'b0; tx_ld_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_loop();
    t_timing();
    t_order();
    t_b2b();
    t_overrun();
    t_rate(0);
    t_rate(1);
    t_rate(3);
    report();
  end
endmodule